// File: doc/BRIEF.md
# LCD Multiplexed Frame Timing Generator

This block produces the common-line timing for a segment LCD driver. One of three oscillator tick streams is chosen and divided by a fixed ratio tied to that source. The divided tick is then counted into sub-phases of a programmable length. Sub-phases are grouped into common phases, and common phases into frames. The number of sub-phases per common and the number of commons per frame both follow the multiplex setting.

Downstream waveform logic reads the active common index and the phase strobe to know when to switch drive levels. It uses the frame-start pulse to flip polarity, and the enable mask to release unused common pins to general-purpose use. The three oscillator inputs are one-cycle enables already synchronous to `clk`.

Configuration inputs are sampled only at a frame boundary, so a frame in progress is never stretched or cut.

Top module: `lcd_frame_timer`

## Requirements
- R1: Multiplex select `mux_sel` encodes 00 = static (1 common), 01 = 1/2 (2 commons), 10 = 1/3 (3 commons), 11 = 1/4 (4 commons). In each frame, `com_idx` steps 0, 1, …, N-1, and `phase_strobe` pulses exactly once in the cycle each new value appears.
- R2: `com_en` is 4'b0001, 4'b0011, 4'b0111 or 4'b1111 for 1, 2, 3 or 4 active commons. Bit k set means COM k is driven.
- R3: A frame lasts (lp+1) × 4 prescaled ticks in static, (lp+1) × 2 × 2 in 1/2, (lp+1) × 3 in 1/3 and (lp+1) × 4 in 1/4 mode.
- R4: `src_sel` 00 picks `main_tick` divided by MAIN_DIV, 01 picks `sec_tick` divided by SEC_DIV, and both 10 and 11 pick `lfi_tick` divided by LFI_DIV.
- R5: `frame_start` is a one-cycle pulse. It is high exactly when `com_idx` returns to 0, and `phase_strobe` is high in the same cycle.
- R6: A change of `lp`, `src_sel` or `mux_sel` during a frame has no effect on that frame's length or on `com_enc`. It takes effect from the next frame start.
- R7: After reset, `com_idx` is 0, both pulses are low and `com_en` is 4'b1111. The first frame runs as 1/4 multiplex, lp = 0, main source, whatever the inputs are. The first `frame_start` follows 4 × MAIN_DIV main ticks after reset is released.
- R8: The full `lp` range 0..15 is honoured, so lp = 15 gives 16 prescaled ticks per sub-phase.
- R9: Common phases inside a frame are equally spaced, each lasting one frame length divided by the number of active commons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main oscillator enable pulse |
| sec_tick | input | 1 | Secondary 32.768 kHz oscillator enable pulse |
| lfi_tick | input | 1 | Low-frequency internal oscillator enable pulse |
| src_sel | input | 2 | Frame clock source select |
| mux_sel | input | 2 | Multiplex mode select |
| lp | input | 4 | Sub-phase length minus one, in prescaled ticks |
| com_idx | output | 2 | Index of the active common line |
| phase_strobe | output | 1 | One-cycle pulse at each common phase start |
| frame_start | output | 1 | One-cycle pulse at each frame start |
| com_en | output | 4 | Mask of commons used by the active mode |

## Verification
The assertions assume that the tick inputs and configuration inputs are synchronous to `clk` and never unknown once reset is released. They also assume that a frame is always at least two clock cycles long, which holds because a frame spans at least three prescaled ticks. The stimulus drives every input on the falling edge from one cycle counter, so the tick streams are strictly periodic. Configuration is changed either while the block is idle in a known frame or exactly at a sampled frame start. Periods are measured only on the second full frame after a change, so that the phase of a newly selected tick stream cannot blur the count.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;
  localparam int NUM_COM = 4;
  localparam int COM_W   = 2;
  localparam int LP_W    = 4;

  typedef enum logic [1:0] {
    MUX_STATIC  = 2'b00,
    MUX_HALF    = 2'b01,
    MUX_THIRD   = 2'b10,
    MUX_QUARTER = 2'b11
  } mux_e;

  typedef enum logic [1:0] {
    SRC_MAIN    = 2'b00,
    SRC_SEC     = 2'b01,
    SRC_LFI     = 2'b10,
    SRC_LFI_ALT = 2'b11
  } src_e;

  // number of commons driven in a mode
  function automatic logic [2:0] com_count(mux_e m);
    return {1'b0, m} + 3'd1;
  endfunction

  // last sub-phase index per common
  function automatic logic [1:0] sub_last(mux_e m);
    case (m)
      MUX_STATIC: return 2'd3;
      MUX_HALF:   return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lcd_ft_prescale.sv
module lcd_ft_prescale
  import lcd_ft_pkg::*;
#(
  parameter int MAIN_DIV = 8192,
  parameter int SEC_DIV  = 32,
  parameter int LFI_DIV  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic main_tick,
  input  logic sec_tick,
  input  logic lfi_tick,
  input  src_e sel,
  output logic pre_tick
);
  localparam int MAX_AB  = (MAIN_DIV > SEC_DIV) ? MAIN_DIV : SEC_DIV;
  localparam int MAX_DIV = (MAX_AB > LFI_DIV) ? MAX_AB : LFI_DIV;
  localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam logic [CNT_W-1:0] MAIN_LAST = CNT_W'(MAIN_DIV - 1);
  localparam logic [CNT_W-1:0] SEC_LAST  = CNT_W'(SEC_DIV - 1);
  localparam logic [CNT_W-1:0] LFI_LAST  = CNT_W'(LFI_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             src;

  always_comb begin
    case (sel)
      SRC_MAIN: begin src = main_tick; last = MAIN_LAST; end
      SRC_SEC:  begin src = sec_tick;  last = SEC_LAST;  end
      default:  begin src = lfi_tick;  last = LFI_LAST;  end
    endcase
  end

  assign pre_tick = src && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (src) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  // a source switch happens only on a wrap, so the count stays in range
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
endmodule

// File: rtl/lcd_ft_sequencer.sv
module lcd_ft_sequencer
  import lcd_ft_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_tick,
  input  logic [LP_W-1:0]  lp_in,
  input  mux_e             mux_in,
  input  src_e             sel_in,
  output src_e             act_sel,
  output logic             wrap,
  output logic [COM_W-1:0] com_idx,
  output logic             phase_strobe,
  output logic             frame_start
);
  logic [LP_W-1:0] act_lp;
  mux_e            act_mux;
  logic [LP_W-1:0] tick_cnt;
  logic [1:0]      sub_cnt;
  logic            tick_last, sub_end, com_end;

  assign tick_last = (tick_cnt == act_lp);
  assign sub_end   = (sub_cnt == sub_last(act_mux));
  assign com_end   = ({1'b0, com_idx} == com_count(act_mux) - 3'd1);
  assign wrap      = pre_tick && tick_last && sub_end && com_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt     <= '0;
      sub_cnt      <= '0;
      com_idx      <= '0;
      act_lp       <= '0;
      act_mux      <= MUX_QUARTER;
      act_sel      <= SRC_MAIN;
      phase_strobe <= 1'b0;
      frame_start  <= 1'b0;
    end else begin
      phase_strobe <= 1'b0;
      frame_start  <= 1'b0;
      if (pre_tick) begin
        if (!tick_last) begin
          tick_cnt <= tick_cnt + 1'b1;
        end else begin
          tick_cnt <= '0;
          if (!sub_end) begin
            sub_cnt <= sub_cnt + 1'b1;
          end else begin
            sub_cnt      <= '0;
            phase_strobe <= 1'b1;
            if (com_end) begin
              com_idx     <= '0;
              frame_start <= 1'b1;
              act_lp      <= lp_in;
              act_mux     <= mux_in;
              act_sel     <= sel_in;
            end else begin
              com_idx <= com_idx + 1'b1;
            end
          end
        end
      end
    end
  end

  assert_tick_bound_R8: assert property (@(posedge clk) disable iff (rst)
    tick_cnt <= act_lp);
  assert_sub_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sub_cnt <= sub_last(act_mux));
  // configuration is held for the whole frame
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> ($stable(act_lp) && $stable(act_mux) && $stable(act_sel)));
endmodule

// File: rtl/lcd_ft_mask.sv
module lcd_ft_mask
  import lcd_ft_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  mux_e               mux_next,
  output logic [NUM_COM-1:0] com_en
);
  for (genvar g = 0; g < NUM_COM; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       com_en[g] <= 1'b1;
      else if (load) com_en[g] <= (3'(g) < com_count(mux_next));
    end
  end

  // enabled commons always form a run starting at COM0
  assert_mask_shape_R2: assert property (@(posedge clk) disable iff (rst)
    com_en[0] && ((com_en & (com_en + 1'b1)) == '0));
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_ft_pkg::*;
#(
  parameter int MAIN_DIV = 8192,
  parameter int SEC_DIV  = 32,
  parameter int LFI_DIV  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      main_tick,
  input  logic                      sec_tick,
  input  logic                      lfi_tick,
  input  logic [1:0]                src_sel,
  input  logic [1:0]                mux_sel,
  input  logic [lcd_ft_pkg::LP_W-1:0]  lp,
  output logic [lcd_ft_pkg::COM_W-1:0] com_idx,
  output logic                      phase_strobe,
  output logic                      frame_start,
  output logic [lcd_ft_pkg::NUM_COM-1:0] com_en
);
  src_e act_sel;
  logic pre_tick;
  logic wrap;

  lcd_ft_prescale #(
    .MAIN_DIV(MAIN_DIV), .SEC_DIV(SEC_DIV), .LFI_DIV(LFI_DIV)
  ) u_pre (
    .clk(clk), .rst(rst),
    .main_tick(main_tick), .sec_tick(sec_tick), .lfi_tick(lfi_tick),
    .sel(act_sel), .pre_tick(pre_tick)
  );

  lcd_ft_sequencer u_seq (
    .clk(clk), .rst(rst), .pre_tick(pre_tick),
    .lp_in(lp), .mux_in(mux_e'(mux_sel)), .sel_in(src_e'(src_sel)),
    .act_sel(act_sel), .wrap(wrap),
    .com_idx(com_idx), .phase_strobe(phase_strobe), .frame_start(frame_start)
  );

  lcd_ft_mask u_mask (
    .clk(clk), .rst(rst), .load(wrap),
    .mux_next(mux_e'(mux_sel)), .com_en(com_en)
  );

  assert_start_at_com0_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (com_idx == '0 && phase_strobe));
  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  assert_idx_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    com_en[com_idx]);
  assert_mask_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(com_en) |-> frame_start);
endmodule

// File: tb/lcd_frame_timer_tb.sv
module lcd_frame_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_tick = 1'b1, sec_tick = 1'b0, lfi_tick = 1'b0;
  logic [1:0] src_sel = 2'd2, mux_sel = 2'd0;
  logic [3:0] lp = 4'd7;
  logic [1:0] com_idx;
  logic       phase_strobe, frame_start;
  logic [3:0] com_en;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  lcd_frame_timer #(.MAIN_DIV(4), .SEC_DIV(3), .LFI_DIV(2)) u_dut (
    .clk(clk), .rst(rst), .main_tick(main_tick), .sec_tick(sec_tick),
    .lfi_tick(lfi_tick), .src_sel(src_sel), .mux_sel(mux_sel), .lp(lp),
    .com_idx(com_idx), .phase_strobe(phase_strobe),
    .frame_start(frame_start), .com_en(com_en)
  );

  // main: every cycle (4 cycles per prescaled tick), sec: every 2nd (6), lfi: every 5th (10)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    sec_tick <= ((cyc + 1) % 2 == 0);
    lfi_tick <= ((cyc + 1) % 5 == 0);
  end

  // {src_sel, mux_sel, lp, expected frame cycles, expected commons}
  localparam logic [20:0] VEC [0:8] = '{
    {2'd0, 2'd0, 4'd2,  10'd48,  3'd1},
    {2'd0, 2'd1, 4'd0,  10'd16,  3'd2},
    {2'd0, 2'd2, 4'd2,  10'd36,  3'd3},
    {2'd0, 2'd3, 4'd1,  10'd32,  3'd4},
    {2'd1, 2'd2, 4'd0,  10'd18,  3'd3},
    {2'd2, 2'd1, 4'd1,  10'd80,  3'd2},
    {2'd3, 2'd3, 4'd0,  10'd40,  3'd4},
    {2'd0, 2'd3, 4'd15, 10'd256, 3'd4},
    {2'd0, 2'd0, 4'd0,  10'd16,  3'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  // called at a negedge where frame_start is high; ends at the next one
  task automatic measure(input int per, input int ncom);
    int n = 0, strobes = 1, last = 0;
    logic [3:0] mask = 4'((1 << ncom) - 1);
    chk(com_idx == 2'd0, "R5 com_idx at frame start", com_idx, 0);
    chk(phase_strobe, "R5 strobe with frame start", phase_strobe, 1);
    chk(com_en == mask, "R2 com_en mask", com_en, mask);
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (frame_start) break;
      if (phase_strobe) begin
        chk(com_idx == 2'(strobes), "R1 com_idx step", com_idx, strobes);
        chk(n - last == per / ncom, "R9 phase spacing", n - last, per / ncom);
        last = n;
        strobes++;
      end
    end
    chk(n == per, "R3,R4,R8 frame length", n, per);
    chk(strobes == ncom, "R1 phases per frame", strobes, ncom);
    chk(per - last == per / ncom, "R9 last phase spacing", per - last, per / ncom);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(com_en == 4'hF, "R7 reset com_en", com_en, 15);
    chk(com_idx == 2'd0, "R7 reset com_idx", com_idx, 0);
    chk(!phase_strobe && !frame_start, "R7 reset pulses", {phase_strobe, frame_start}, 0);
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start && n < 1000);
    chk(n == 16, "R7 first frame uses defaults", n, 16);
    chk(com_en == 4'h1, "R7 inputs loaded at first boundary", com_en, 1);

    for (int i = 0; i < 9; i++) begin
      src_sel = VEC[i][20:19];
      mux_sel = VEC[i][18:17];
      lp      = VEC[i][16:13];
      wait_fs();
      wait_fs();
      measure(int'(VEC[i][12:3]), int'(VEC[i][2:0]));
    end

    // R6: settle on 1/4, lp=1, main; then change everything at a frame start
    src_sel = 2'd0; mux_sel = 2'd3; lp = 4'd1;
    wait_fs();
    wait_fs();
    src_sel = 2'd1; mux_sel = 2'd0; lp = 4'd3;
    measure(32, 4);
    chk(com_en == 4'h1, "R6 new mask after boundary", com_en, 1);
    // second frame on the new source is in steady state: 6*4*4 cycles
    wait_fs();
    measure(96, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule